// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block takes a free-running input clock and produces an output at the input rate divided by 1, 2, 4 or 8. A chain of toggle stages counts falling edges of the input. The first stage is clocked by the input, and each later stage is clocked by the falling edge of the stage before it. A two-bit mode select picks which tap reaches the output. Tap zero is the raw input clock, so the lowest mode is a straight pass-through.

An active-low reset works asynchronously. It clears every stage and takes the output off the line. The high-impedance state is represented by an output-enable flag that sits beside the data bit. When the enable is low, the data bit is held LOW. The levels that the pull-ups would give an undriven pin are modelled as inputs tied to that level: all-ones on the select and HIGH on the reset.

Top module: `clkdiv_sel`

## Requirements
- R1: The select encoding is `mode_sel` 2'b00 for divide-by-1, 2'b01 for divide-by-2, 2'b10 for divide-by-4 and 2'b11 for divide-by-8. Bit 1 is the more significant select line. In divide-by-1 the data output follows the level of `clk_in` directly.
- R2: The divider state changes only on falling edges of `clk_in`. In the divided modes, the output holds its value across rising edges of `clk_in`.
- R3: Stage k toggles on the falling edge of stage k-1. After reset release in divide-by-2^k, the output is LOW and first rises on falling edge 2^(k-1) of `clk_in`.
- R4: A LOW on `rst_n` clears every stage at once, whatever the clock is doing. While it stays LOW, clock edges change nothing at the output.
- R5: While `rst_n` is LOW, `dout_en` is 0 and `dout` is 0, and the enable falls in the same time step as the reset. On release `dout_en` rises at once. In divide-by-1 with `clk_in` HIGH, `dout` goes HIGH at once.
- R6: In every mode the output period equals the ratio times the input period, and the output is HIGH for exactly half of each period.
- R7: A change of `mode_sel` while running reaches the output at once. The stages keep counting and are not cleared by the change.
- R8: The all-ones select, which is the level an unconnected select reads, gives divide-by-8. `rst_n` held HIGH lets the block run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided; stages advance on its falling edge |
| rst_n | input | 1 | Asynchronous active-low clear; also disables the output |
| mode_sel | input | 2 | Division ratio select (R1 encoding) |
| dout | output | 1 | Divided clock data bit, LOW while disabled |
| dout_en | output | 1 | Output enable; 0 stands for high impedance |

## Verification
The hardest state to reach from the ports is a mode change in the middle of a count. In that case the output must jump to a different tap while the hidden count carries on untouched. The stimulus runs divide-by-8 for ten falling edges, which leaves the count at a known non-zero value. It then switches mode between clock edges and compares the output with the bits of that count. One more falling edge shows that the count kept its value. Reset is released just after a rising edge, so that a full half-period passes before the next falling edge. This makes the divide-by-1 enable-HIGH case and the first-rise positions land at exact, predictable samples.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

   localparam int unsigned DEF_STAGES = 3;

   // select width needed to address the raw clock plus every stage tap
   function automatic int unsigned tap_sel_width(input int unsigned stages);
      return (stages < 1) ? 1 : $clog2(stages + 1);
   endfunction

   // number of taps a chain of the given depth exposes
   function automatic int unsigned tap_count(input int unsigned stages);
      return stages + 1;
   endfunction

endpackage

// File: rtl/clkdiv_toggle_stage.sv
`timescale 1ns/1ps
module clkdiv_toggle_stage (
   input  logic clk_src,
   input  logic rst_n,
   output logic q
);

   always_ff @(negedge clk_src or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ~q;
   end

endmodule

// File: rtl/clkdiv_ripple_chain.sv
`timescale 1ns/1ps
module clkdiv_ripple_chain #(
   parameter int unsigned NUM_STAGES = clkdiv_pkg::DEF_STAGES
) (
   input  logic                  clk_in,
   input  logic                  rst_n,
   output logic [NUM_STAGES-1:0] cnt
);

   generate
      if (NUM_STAGES < 2) begin : g_bad_depth
         $error("clkdiv_ripple_chain: NUM_STAGES must be at least 2");
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < NUM_STAGES; k++) begin : g_stage
         logic stage_clk;
         if (k == 0) begin : g_first
            assign stage_clk = clk_in;
         end else begin : g_next
            assign stage_clk = cnt[k-1];
         end
         clkdiv_toggle_stage u_stage (
            .clk_src (stage_clk),
            .rst_n   (rst_n),
            .q       (cnt[k])
         );
      end
   endgenerate

endmodule

// File: rtl/clkdiv_tap_mux.sv
`timescale 1ns/1ps
module clkdiv_tap_mux #(
   parameter int unsigned NUM_STAGES = clkdiv_pkg::DEF_STAGES,
   parameter int unsigned SEL_W      = clkdiv_pkg::tap_sel_width(NUM_STAGES)
) (
   input  logic                  clk_in,
   input  logic [NUM_STAGES-1:0] cnt,
   input  logic [SEL_W-1:0]      mode_sel,
   input  logic                  enable,
   output logic                  tap_out
);

   localparam int unsigned N_TAPS = clkdiv_pkg::tap_count(NUM_STAGES);
   localparam int unsigned N_CODES = 1 << SEL_W;

   logic [N_TAPS-1:0] taps;
   logic              picked;

   assign taps = {cnt, clk_in};

   generate
      if (N_TAPS == N_CODES) begin : g_full
         // every select code addresses a tap
         assign picked = taps[mode_sel];
      end else begin : g_partial
         // codes beyond the last tap fall back to the deepest stage
         always_comb begin
            if (32'(mode_sel) < N_TAPS) picked = taps[mode_sel];
            else                        picked = taps[N_TAPS-1];
         end
      end
   endgenerate

   assign tap_out = enable & picked;

endmodule

// File: rtl/clkdiv_sel.sv
`timescale 1ns/1ps
module clkdiv_sel #(
   parameter int unsigned NUM_STAGES = clkdiv_pkg::DEF_STAGES
) (
   input  logic       clk_in,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   output logic       dout,
   output logic       dout_en
);

   localparam int unsigned SEL_W = clkdiv_pkg::tap_sel_width(NUM_STAGES);

   generate
      if (SEL_W != 2) begin : g_bad_sel
         $error("clkdiv_sel: the two-bit select needs NUM_STAGES of 2 or 3");
      end
   endgenerate

   logic [NUM_STAGES-1:0] cnt_q;

   clkdiv_ripple_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .cnt    (cnt_q)
   );

   clkdiv_tap_mux #(.NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W)) u_mux (
      .clk_in   (clk_in),
      .cnt      (cnt_q),
      .mode_sel (mode_sel),
      .enable   (rst_n),
      .tap_out  (dout)
   );

   assign dout_en = rst_n;

endmodule

// File: rtl/clkdiv_sel_chk.sv
`timescale 1ns/1ps
module clkdiv_sel_chk #(
   parameter int unsigned NUM_STAGES = clkdiv_pkg::DEF_STAGES
) (
   input logic                  clk_in,
   input logic                  rst_n,
   input logic [NUM_STAGES-1:0] cnt,
   input logic                  dout,
   input logic                  dout_en
);

   AST_FIRST_STAGE_TOGGLES: assert property (@(negedge clk_in) disable iff (!rst_n)
      $past(rst_n) |-> (cnt[0] != $past(cnt[0])));                               // R2

   AST_UPPER_HOLD_ON_RISE: assert property (@(negedge clk_in) disable iff (!rst_n)
      ($past(rst_n) && !$past(cnt[0])) |-> $stable(cnt[NUM_STAGES-1:1]));         // R3

   AST_RESET_CLEARS: assert property (@(posedge clk_in)
      !rst_n |-> (cnt == '0));                                                    // R4

   AST_OFF_DRIVES_LOW: assert property (@(posedge clk_in)
      !dout_en |-> !dout);                                                        // R5

   AST_RESET_DISABLES: assert property (@(negedge clk_in)
      !rst_n |-> !dout_en);                                                       // R5

endmodule

bind clkdiv_sel clkdiv_sel_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
   .clk_in  (clk_in),
   .rst_n   (rst_n),
   .cnt     (cnt_q),
   .dout    (dout),
   .dout_en (dout_en)
);

// File: tb/tb_clkdiv_sel.sv
`timescale 1ns/1ps
module tb_clkdiv_sel;

   logic       clk_in   = 1'b1;
   logic       rst_n    = 1'b1;
   logic [1:0] mode_sel = 2'b11;
   logic       dout;
   logic       dout_en;

   int checks   = 0;
   int failures = 0;

   always #2 clk_in = ~clk_in;   // 250 MHz

   clkdiv_sel dut (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .dout     (dout),
      .dout_en  (dout_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // enter reset, verify it holds against a running clock, release just after a rising edge
   task automatic hold_reset(input logic [1:0] m);
      rst_n = 1'b0;
      mode_sel = m;
      #0.1;
      check(dout_en == 1'b0, "R5 enable drops with reset", int'(dout_en), 0);
      repeat (3) @(negedge clk_in);
      #1;
      check(dout_en == 1'b0 && dout == 1'b0, "R4 clock ignored in reset",
            int'({dout_en, dout}), 0);
      @(posedge clk_in);
      #0.5;
      rst_n = 1'b1;
      #0.2;
      check(dout_en == 1'b1, "R5 enable on release", int'(dout_en), 1);
   endtask

   task automatic run_mode(input logic [1:0] m);
      int  n     = 1 << m;
      int  nhalf = 32 * n;
      int  f     = 0;
      int  mism  = 0;
      int  fact  = 0;
      int  fexp  = 0;
      int  r1    = -1;
      int  r2    = -1;
      int  first = -1;
      int  highs = 0;
      logic s [0:511];
      hold_reset(m);
      if (m == 2'd0) check(dout == 1'b1, "R1 R5 pass-through high on release", int'(dout), 1);
      else           check(dout == 1'b0, "R3 output low on release", int'(dout), 0);
      for (int h = 0; h < nhalf; h++) begin
         int ex;
         @(clk_in);
         if (clk_in == 1'b0) f++;
         #1;
         ex = (m == 2'd0) ? int'(clk_in) : ((f >> (m - 1)) & 1);
         if (!(dout_en == 1'b1 && int'(dout) == ex)) begin
            if (mism == 0) begin fact = int'(dout); fexp = ex; end
            mism++;
         end
         s[h] = dout;
      end
      check(mism == 0, $sformatf("R1 R2 R8 waveform mode %0d", m), fact, fexp);
      for (int h = 1; h < nhalf; h++) begin
         if (s[h-1] == 1'b0 && s[h] == 1'b1) begin
            if (r1 < 0) r1 = h;
            else if (r2 < 0) r2 = h;
         end
      end
      for (int h = 0; h < nhalf; h++) if (first < 0 && s[h] == 1'b1) first = h;
      check(r2 - r1 == 2 * n, $sformatf("R6 period mode %0d", m), r2 - r1, 2 * n);
      for (int h = r1; h < r2; h++) if (s[h] == 1'b1) highs++;
      check(highs == n, $sformatf("R6 duty mode %0d", m), highs, n);
      if (m != 2'd0)
         check(first == 2 * (n / 2 - 1), $sformatf("R3 first rise mode %0d", m),
               first, 2 * (n / 2 - 1));
   endtask

   task automatic mode_switch_test();
      hold_reset(2'b11);
      repeat (10) @(negedge clk_in);   // count now 3'b010
      #1;
      check(dout == 1'b0, "R7 divide-by-8 bit before switch", int'(dout), 0);
      mode_sel = 2'b10;
      #0.2;
      check(dout == 1'b1, "R7 switch to divide-by-4 immediate", int'(dout), 1);
      mode_sel = 2'b01;
      #0.2;
      check(dout == 1'b0, "R7 switch to divide-by-2 immediate", int'(dout), 0);
      @(negedge clk_in);               // count 3'b011
      #1;
      check(dout == 1'b1, "R7 count kept across switch", int'(dout), 1);
      mode_sel = 2'b10;
      #0.2;
      check(dout == 1'b1, "R7 stage 1 kept across switch", int'(dout), 1);
   endtask

   task automatic midrun_reset_test();
      hold_reset(2'b01);
      repeat (5) @(negedge clk_in);
      #1;
      check(dout == 1'b1, "R2 divide-by-2 after five falls", int'(dout), 1);
      @(posedge clk_in);
      #1;
      check(dout == 1'b1, "R2 held across rising edge", int'(dout), 1);
      rst_n = 1'b0;
      #0.1;
      check(dout_en == 1'b0 && dout == 1'b0, "R4 R5 async clear mid-run",
            int'({dout_en, dout}), 0);
      @(posedge clk_in);
      #0.5;
      rst_n = 1'b1;
      #0.2;
      check(dout == 1'b0, "R4 stages cleared", int'(dout), 0);
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #0.5;
      rst_n = 1'b0;
      #1;
      check(dout_en == 1'b0 && dout == 1'b0, "R5 reset state", int'({dout_en, dout}), 0);
      run_mode(2'b11);   // R8 default select level
      run_mode(2'b00);
      run_mode(2'b01);
      run_mode(2'b10);
      midrun_reset_test();
      mode_switch_test();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule